// File: doc/BRIEF.md
# Phase-Shifted Multicarrier PWM Generator

This block produces the switch commands for six two-level three-phase inverter modules whose outputs are combined into one multilevel converter. Three triangular carriers, spaced a third of a carrier period apart, are derived from a single up/down count. Each carrier serves two modules. The first module of the pair compares the three phase references against the carrier directly. The second module compares the same references against the carrier mirrored about its peak.

The references come from a 32-bit phase accumulator and a quarter-wave sine table. A third-harmonic term at one sixth of the fundamental is added to each phase. This lets the modulation index go about 15% above unity before the reference clips. The sum is scaled by the modulation index and saturated. It is then mapped onto the carrier range, so the comparison holds for any programmed carrier period.

Each of the 18 leg commands drives a complementary upper/lower gate pair. A programmable dead interval holds both gates off after every transition.

Top module: `phase_shift_pwm`

## Requirements
- R1: A counter runs 0..6T-1 while enabled, where T is `carrier_third` (0 is treated as 1), and it is cleared while disabled. Carrier j (j = 0, 1, 2) takes x = (count + 2·j·T) mod 6T and equals x when x ≤ 3T, otherwise 6T − x. The carrier peak is 3T.
- R2: Leg bit 3·m + p, for module m in 0..2 and phase p (0 = A, 1 = B, 2 = C), is high when the level of phase p is greater than or equal to carrier m.
- R3: Leg bit 3·m + p, for module m in 3..5, is high when the level of phase p is greater than or equal to 3T minus carrier m−3.
- R4: The accumulator is 32 bits wide. It adds `phase_step` on every enabled cycle and is cleared while disabled. Phase A uses the accumulator value, B uses the accumulator minus 0x55555555, and C uses the accumulator plus 0x55555555. A sine sample for phase word φ, with k = φ[31:24], is round(2047·sin(2π(k+0.5)/256)), rounded half away from zero.
- R5: The third-harmonic term is the sine sample of 3·φ mod 2^32. It is divided by 6, truncated toward zero, and added to the fundamental sample.
- R6: The sum is multiplied by `mod_index`, an unsigned value where 512 = 1.0, then arithmetically shifted right by 9 and clipped to ±2047. The phase level is ((v + 2048)·3T) >> 12.
- R7: Leg commands are registered. The value seen after a clock edge is computed from the counter, the accumulator and the inputs present before that edge.
- R8: While reset is active or `enable` is low, all leg commands and all gates are low. The cycle after `enable` falls, they are all low.
- R9: After a leg command changes, both of its gates stay low for `dead_cycles`+1 cycles. After that, `gate_hi` follows the leg and `gate_lo` follows its inverse. The same dead interval also follows re-enabling.
- R10: The upper and lower gate of a leg are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Run enable; low forces outputs off and restarts the counters |
| mod_index | input | 10 | Modulation index, 512 = 1.0 |
| carrier_third | input | 8 | One third of the carrier period, in clocks |
| phase_step | input | 32 | Reference phase increment per clock |
| dead_cycles | input | 6 | Dead-interval length setting |
| leg_cmd | output | 18 | Leg commands, bit 3·module + phase |
| gate_hi | output | 18 | Upper gate per leg |
| gate_lo | output | 18 | Lower gate per leg |

## Verification
Two functions can land in the same cycle. The first case is a fresh leg transition that arrives while the dead interval of the previous one is still counting. The second case is a fall of `enable` in the cycle where legs switch. The first case is provoked by the shortest carrier period (setting 0, six clocks) with a dead setting of 7, so legs flip before the interval ends. The second case is provoked by dropping `enable` for a few cycles in the middle of a live run. A cycle-accurate scoreboard judges both. Its gate model is driven by the observed leg commands, and every cycle it also checks that no gate pair overlaps.

// File: rtl/mcpwm_pkg.sv
package mcpwm_pkg;
   localparam int N_PHASE = 3;
   localparam int N_MOD   = 6;
   localparam int N_LEG   = N_PHASE * N_MOD;
   // pi scaled by 2^30
   localparam longint PI_Q30 = 64'sd3373259426;

   // Rounded amplitude * sin of the centre of quarter-wave bin idx (Taylor series in Q30).
   function automatic int quarter_sine(input int idx, input int depth, input int amp);
      longint x, x2, term, acc;
      x    = (PI_Q30 * longint'(2 * idx + 1)) / longint'(4 * depth);
      x2   = (x * x) >>> 30;
      term = x;
      acc  = x;
      for (int k = 1; k <= 7; k++) begin
         term = -((term * x2) >>> 30) / longint'((2 * k) * (2 * k + 1));
         acc  = acc + term;
      end
      return int'((acc * longint'(amp) + (64'sd1 <<< 29)) >>> 30);
   endfunction
endpackage

// File: rtl/mcpwm_carrier.sv
module mcpwm_carrier #(
   parameter int TW = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  en,
   input  logic [TW-1:0]         third,
   output logic [TW+2:0]         peak,
   output logic [2:0][TW+2:0]    car
);
   localparam int CW = TW + 3;

   logic [CW-1:0] t_eff, span, cnt;

   always_comb begin
      t_eff = (third == '0) ? CW'(1) : CW'(third);
      span  = (t_eff << 2) + (t_eff << 1);
      peak  = (t_eff << 1) + t_eff;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt <= '0;
      else if (!en)               cnt <= '0;
      else if (cnt >= span - 1'b1) cnt <= '0;
      else                        cnt <= cnt + 1'b1;
   end

   for (genvar j = 0; j < 3; j++) begin : g_car
      localparam int J2 = 2 * j;
      logic [CW:0] pos;
      always_comb begin
         pos = {1'b0, cnt} + (CW+1)'(J2) * {1'b0, t_eff};
         if (pos >= {1'b0, span}) pos = pos - {1'b0, span};
         car[j] = (pos > {1'b0, peak}) ? CW'({1'b0, span} - pos) : CW'(pos);
      end
   end

   // R1: counter restarts from zero whenever enable is low
   p_restart_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> cnt == '0);
   // R1: wrap at the end of the period
   p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (en && $stable(third) && cnt == span - 1'b1) |=> cnt == '0);
   // R1: steady counting inside the period
   p_count_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (en && $stable(third) && cnt < span - 1'b1) |=> cnt == $past(cnt) + 1'b1);
endmodule

// File: rtl/mcpwm_ref.sv
module mcpwm_ref
   import mcpwm_pkg::*;
#(
   parameter int RW = 12,
   parameter int MW = 10,
   parameter int TW = 8,
   parameter int QB = 6
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 en,
   input  logic [31:0]          step,
   input  logic [MW-1:0]        mod_idx,
   input  logic [TW+2:0]        peak,
   output logic [2:0][TW+2:0]   lvl
);
   localparam int CW  = TW + 3;
   localparam int QD  = 1 << QB;
   localparam int AMP = (1 << (RW - 1)) - 1;
   localparam logic signed [RW+MW+1:0] HI  = (RW+MW+2)'(AMP);
   localparam logic signed [RW+MW+1:0] LO  = -(RW+MW+2)'(AMP);
   localparam logic signed [RW:0]      SIX = (RW+1)'(6);
   localparam logic signed [RW:0]      MID = (RW+1)'(1 << (RW - 1));

   logic [RW-2:0] qtab [QD];
   for (genvar g = 0; g < QD; g++) begin : g_tab
      localparam int V = quarter_sine(g, QD, AMP);
      assign qtab[g] = (RW-1)'(V);
   end

   logic [31:0] acc;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   acc <= '0;
      else if (!en) acc <= '0;
      else          acc <= acc + step;
   end

   for (genvar p = 0; p < 3; p++) begin : g_ph
      localparam logic [31:0] OFS = (p == 0) ? 32'h0 : (p == 1) ? 32'hAAAA_AAAB : 32'h5555_5555;
      logic [31:0]             ph, ph3;
      logic [RW-2:0]           m1, m3;
      logic signed [RW:0]      f1, f3, sum, clip, uni;
      logic signed [RW+MW+1:0] prod, sc;
      logic [RW+CW-1:0]        full;
      always_comb begin
         ph   = acc + OFS;
         ph3  = ph + {ph[30:0], 1'b0};
         m1   = ph[30]  ? qtab[~ph[29 -: QB]]  : qtab[ph[29 -: QB]];
         m3   = ph3[30] ? qtab[~ph3[29 -: QB]] : qtab[ph3[29 -: QB]];
         f1   = ph[31]  ? -$signed({2'b00, m1}) : $signed({2'b00, m1});
         f3   = ph3[31] ? -$signed({2'b00, m3}) : $signed({2'b00, m3});
         sum  = f1 + f3 / SIX;
         prod = sum * $signed({1'b0, mod_idx});
         sc   = prod >>> (MW - 1);
         if (sc > HI)      clip = HI[RW:0];
         else if (sc < LO) clip = LO[RW:0];
         else              clip = sc[RW:0];
         uni  = clip + MID;
         full = uni[RW-1:0] * peak;
         lvl[p] = CW'(full >> RW);
      end

      // R6: mapped level always stays below the carrier peak
      p_level_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
         lvl[p] < peak);
   end

   // R4: accumulator cleared while disabled
   p_acc_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> acc == '0);
   // R4: accumulator advances by the step while enabled
   p_acc_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      en |=> acc == $past(acc) + $past(step));
endmodule

// File: rtl/mcpwm_deadband.sv
module mcpwm_deadband #(
   parameter int DW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          leg,
   input  logic [DW-1:0] dead,
   output logic          gate_hi,
   output logic          gate_lo
);
   logic          lprev;
   logic [DW-1:0] dcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lprev   <= 1'b0;
         dcnt    <= '0;
         gate_hi <= 1'b0;
         gate_lo <= 1'b0;
      end else begin
         lprev <= leg;
         if (!en || leg != lprev) begin
            dcnt    <= dead;
            gate_hi <= 1'b0;
            gate_lo <= 1'b0;
         end else if (dcnt != '0) begin
            dcnt    <= dcnt - 1'b1;
            gate_hi <= 1'b0;
            gate_lo <= 1'b0;
         end else begin
            gate_hi <= leg;
            gate_lo <= ~leg;
         end
      end
   end

   // R10: complementary gates never overlap
   p_no_overlap_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(gate_hi && gate_lo));
   // R9: a leg transition opens a dead interval
   p_dead_open_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (en && leg != lprev) |=> (!gate_hi && !gate_lo));
   // R9: once the interval has elapsed the upper gate tracks the leg
   p_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (en && leg == lprev && dcnt == '0) |=> gate_hi == $past(leg));
   // R8: disabled means both gates off
   p_gates_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!gate_hi && !gate_lo));
endmodule

// File: rtl/phase_shift_pwm.sv
module phase_shift_pwm
   import mcpwm_pkg::*;
#(
   parameter int RW = 12,
   parameter int MW = 10,
   parameter int TW = 8,
   parameter int DW = 6,
   parameter int QB = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               enable,
   input  logic [MW-1:0]      mod_index,
   input  logic [TW-1:0]      carrier_third,
   input  logic [31:0]        phase_step,
   input  logic [DW-1:0]      dead_cycles,
   output logic [N_LEG-1:0]   leg_cmd,
   output logic [N_LEG-1:0]   gate_hi,
   output logic [N_LEG-1:0]   gate_lo
);
   localparam int CW = TW + 3;

   initial begin
      assert (RW >= 8 && RW <= 16) else $error("RW out of range");
      assert (MW >= 2 && MW <= 16) else $error("MW out of range");
      assert (TW >= 2 && TW <= 16) else $error("TW out of range");
      assert (QB >= 3 && QB <= 8 && QB <= RW - 2) else $error("QB out of range");
      assert (DW >= 1) else $error("DW out of range");
   end

   logic [CW-1:0]         peak;
   logic [2:0][CW-1:0]    car;
   logic [2:0][CW-1:0]    lvl;
   logic [N_LEG-1:0]      hit;

   mcpwm_carrier #(.TW(TW)) u_car (
      .clk(clk), .rst_n(rst_n), .en(enable), .third(carrier_third),
      .peak(peak), .car(car)
   );

   mcpwm_ref #(.RW(RW), .MW(MW), .TW(TW), .QB(QB)) u_ref (
      .clk(clk), .rst_n(rst_n), .en(enable), .step(phase_step),
      .mod_idx(mod_index), .peak(peak), .lvl(lvl)
   );

   for (genvar m = 0; m < N_MOD; m++) begin : g_mod
      logic [CW-1:0] cval;
      if (m < 3) begin : g_direct
         assign cval = car[m];
      end else begin : g_mirror
         assign cval = peak - car[m-3];
      end
      for (genvar p = 0; p < N_PHASE; p++) begin : g_leg
         assign hit[3*m+p] = (lvl[p] >= cval);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       leg_cmd <= '0;
      else if (!enable) leg_cmd <= '0;
      else              leg_cmd <= hit;
   end

   for (genvar l = 0; l < N_LEG; l++) begin : g_db
      mcpwm_deadband #(.DW(DW)) u_db (
         .clk(clk), .rst_n(rst_n), .en(enable), .leg(leg_cmd[l]),
         .dead(dead_cycles), .gate_hi(gate_hi[l]), .gate_lo(gate_lo[l])
      );
   end

   // R8: legs are off the cycle after enable is low
   p_leg_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> leg_cmd == '0);
endmodule

// File: tb/tb_phase_shift_pwm.sv
module tb_phase_shift_pwm;
   localparam int MW = 10, TW = 8, DW = 6, NL = 18;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic enable = 1'b0;
   logic [MW-1:0] mod_index = '0;
   logic [TW-1:0] carrier_third = 8'd4;
   logic [31:0]   phase_step = '0;
   logic [DW-1:0] dead_cycles = 6'd2;
   logic [NL-1:0] leg_cmd, gate_hi, gate_lo;

   always #5 clk = ~clk;

   phase_shift_pwm dut (
      .clk(clk), .rst_n(rst_n), .enable(enable), .mod_index(mod_index),
      .carrier_third(carrier_third), .phase_step(phase_step),
      .dead_cycles(dead_cycles), .leg_cmd(leg_cmd), .gate_hi(gate_hi), .gate_lo(gate_lo)
   );

   int checks = 0;
   int fails = 0;
   bit done = 0;

   typedef struct {
      logic [NL-1:0] leg;
      logic [NL-1:0] mask;
      logic [NL-1:0] hi;
      logic [NL-1:0] lo;
      bit            idle;
   } exp_t;
   exp_t sb[$];

   // bench model state
   int            m_cnt = 0;
   logic [31:0]   m_acc = '0;
   logic [NL-1:0] m_lprev = '0, m_hi = '0, m_lo = '0, obs_leg = '0;
   int            m_dcnt [NL];

   // R4: sine sample rounded half away from zero
   function automatic int bsin(input logic [31:0] ph);
      real x;
      x = 2047.0 * $sin(6.283185307179586 * (real'(ph[31:24]) + 0.5) / 256.0);
      if (x >= 0.0) return $rtoi(x + 0.5);
      return -$rtoi(-x + 0.5);
   endfunction

   // R5 R6: harmonic injection, scaling, clipping, mapping to the carrier range
   function automatic int exp_lvl(input logic [31:0] ph, input int m, input int te);
      logic [31:0] ph3;
      int s, v;
      ph3 = ph * 32'd3;
      s = bsin(ph) + bsin(ph3) / 6;
      v = (s * m) >>> 9;
      if (v > 2047) v = 2047;
      if (v < -2047) v = -2047;
      return ((v + 2048) * 3 * te) >>> 12;
   endfunction

   // model: predicts the outputs after each edge
   always @(posedge clk) begin : model
      exp_t e;
      int te, span, peak, pos, c;
      int lv [3];
      logic [31:0] ofs [3];
      ofs[0] = 32'h0; ofs[1] = 32'hAAAA_AAAB; ofs[2] = 32'h5555_5555;
      e.leg = '0; e.mask = '1; e.hi = '0; e.lo = '0; e.idle = 1'b1;
      if (!rst_n) begin
         m_cnt = 0; m_acc = '0; m_lprev = '0; m_hi = '0; m_lo = '0;
         for (int l = 0; l < NL; l++) m_dcnt[l] = 0;
      end else begin
         te   = (carrier_third == 0) ? 1 : int'(carrier_third);
         span = 6 * te;
         peak = 3 * te;
         e.idle = !enable;
         for (int p = 0; p < 3; p++) lv[p] = exp_lvl(m_acc + ofs[p], int'(mod_index), te);
         for (int mo = 0; mo < 6; mo++) begin
            pos = m_cnt + 2 * te * (mo % 3);
            if (pos >= span) pos = pos - span;
            c = (pos > peak) ? span - pos : pos;   // R1
            if (mo >= 3) c = peak - c;             // R3 mirrored carrier
            for (int p = 0; p < 3; p++) begin
               e.leg[3*mo+p] = enable && (lv[p] >= c);   // R2 R3
               if (enable && (lv[p] - c <= 1) && (c - lv[p] <= 1)) e.mask[3*mo+p] = 1'b0;
            end
         end
         for (int l = 0; l < NL; l++) begin       // R9 gate model from observed legs
            if (!enable || obs_leg[l] != m_lprev[l]) begin
               m_dcnt[l] = int'(dead_cycles); m_hi[l] = 1'b0; m_lo[l] = 1'b0;
            end else if (m_dcnt[l] != 0) begin
               m_dcnt[l] = m_dcnt[l] - 1; m_hi[l] = 1'b0; m_lo[l] = 1'b0;
            end else begin
               m_hi[l] = obs_leg[l]; m_lo[l] = !obs_leg[l];
            end
            m_lprev[l] = obs_leg[l];
         end
         e.hi = m_hi; e.lo = m_lo;
         if (!enable)              m_cnt = 0;
         else if (m_cnt >= span - 1) m_cnt = 0;
         else                      m_cnt = m_cnt + 1;
         m_acc = enable ? m_acc + phase_step : 32'h0;
      end
      sb.push_back(e);
   end

   // monitor: compares away from the active edge
   always @(negedge clk) begin : monitor
      exp_t e;
      obs_leg = leg_cmd;
      if (sb.size() != 0) begin
         e = sb.pop_front();
         checks++;
         if (((leg_cmd ^ e.leg) & e.mask) != '0) begin
            fails++;
            if (e.idle)
               $display("FAIL R8 idle legs: actual %h expected %h", leg_cmd, e.leg);
            else
               $display("FAIL R2 R3 leg compare (carrier R1, reference R4 R5 R6, latency R7): actual %h expected %h mask %h",
                        leg_cmd, e.leg, e.mask);
         end
         checks++;
         if (gate_hi != e.hi || gate_lo != e.lo) begin
            fails++;
            $display("FAIL R9 gates: actual hi %h lo %h expected hi %h lo %h", gate_hi, gate_lo, e.hi, e.lo);
         end
         checks++;
         if ((gate_hi & gate_lo) != '0) begin
            fails++;
            $display("FAIL R10 overlap: actual %h expected 0", gate_hi & gate_lo);
         end
      end
   end

   task automatic setup(input int t, input int d, input int m, input logic [31:0] s, input bit en);
      @(negedge clk);
      carrier_third = TW'(t);
      dead_cycles   = DW'(d);
      mod_index     = MW'(m);
      phase_step    = s;
      enable        = en;
   endtask

   task automatic run(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_up();
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R8: reset state
      checks++;
      if (leg_cmd != '0 || gate_hi != '0 || gate_lo != '0) begin
         fails++;
         $display("FAIL R8 reset: actual %h %h %h expected 0 0 0", leg_cmd, gate_hi, gate_lo);
      end
      rst_n = 1'b1;
      run(4);
      // R2 R3: static references, unity index
      setup(4, 2, 512, 32'd0, 1'b1);           run(120);
      setup(4, 2, 512, 32'd0, 1'b0);           run(10);   // R8
      // R4 R5: running references at 0.95
      setup(4, 2, 486, 32'd11930465, 1'b1);    run(2000);
      // R6: saturation at maximum index
      setup(4, 3, 1023, 32'd11930465, 1'b1);   run(1500);
      // R6: zero index, all references at mid level
      setup(4, 1, 0, 32'd11930465, 1'b1);      run(200);
      // R1 R9: shortest period with a dead interval longer than a half period
      setup(4, 7, 560, 32'd7158279, 1'b0);     run(3);
      setup(0, 7, 560, 32'd7158279, 1'b1);     run(400);
      // R1: non-multiple period, zero dead time
      setup(0, 0, 560, 32'd4294967, 1'b0);     run(3);
      setup(5, 0, 560, 32'd4294967, 1'b1);     run(3000);
      // R8 R9: enable drop in a live run
      setup(5, 2, 560, 32'd4294967, 1'b0);     run(3);
      setup(5, 2, 560, 32'd4294967, 1'b1);     run(300);
      setup(5, 2, 560, 32'd4294967, 1'b0);     run(1);
      setup(5, 2, 560, 32'd4294967, 1'b1);     run(500);
      // R1: widest period
      setup(5, 4, 600, 32'd1431655, 1'b0);     run(3);
      setup(255, 4, 600, 32'd1431655, 1'b1);   run(3500);
      setup(255, 4, 600, 32'd1431655, 1'b0);   run(5);
      done = 1;
      finish_up();
   end

   initial begin
      #2_000_000;
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         finish_up();
      end
   end
endmodule